// File: doc/BRIEF.md
# Rotate-Through-Carry-Right Unit

This block rotates an operand to the right through the carry flag and returns the new value together with an updated flags word. The operand may be 8, 16, 32 or 64 bits wide. The carry flag is a member of the rotating ring, so the ring is one bit wider than the selected operand width. On each single step, bit 0 of the operand moves into the carry and the old carry moves into the top bit of the operand.

Each request is presented for one cycle with `in_valid` high. It carries the operand, a raw rotate count, the incoming flags word and a size code. Exactly one clock later the unit presents a registered result and flags word, marked by `out_valid`. The rotation is done by a barrel structure, one lane for each size, so every count costs the same single cycle. Only the carry and overflow positions of the flags word are rewritten.

Top module: `rcr_unit`

## Requirements
- R1: The raw count is masked to its low 6 bits for the 64-bit size and to its low 5 bits for the 8, 16 and 32-bit sizes; higher count bits have no effect.
- R2: After masking, the count is reduced modulo 9 for 8-bit, modulo 17 for 16-bit and modulo 33 for 32-bit operands, with no reduction for 64-bit operands.
- R3: The result equals the ring {carry, operand[w-1:0]} of width w+1 rotated right by the effective count. The result is its low w bits and the new carry is its top bit.
- R4: Overflow (flags bit 11) is set to incoming carry (flags bit 0) XOR operand bit w-1, taken before rotation.
- R5: Overflow is produced by the rule in R4 even when the effective count is zero.
- R6: Every flags bit other than bit 0 (carry) and bit 11 (overflow) is passed from `flags_in` to `flags_out` unchanged.
- R7: Only operand bits below the selected width take part, and result bits at and above that width are zero.
- R8: With an effective count of zero, the result equals the operand's low w bits and the output carry equals the input carry.
- R9: `size_sel` encodes the width as 00 for 8, 01 for 16, 10 for 32 and 11 for 64 bits.
- R10: `result`, `flags_out` and `out_valid` update on the clock edge after `in_valid` is sampled high. `out_valid` is high for exactly one cycle per request, and the outputs hold while `in_valid` is low.
- R11: While `rst` is high, at each clock edge `out_valid`, `result` and `flags_out` are cleared to zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request strobe |
| operand | input | 64 | Value to rotate; only the low w bits are used |
| count | input | 8 | Raw rotate count |
| flags_in | input | 64 | Incoming flags word, carry at bit 0 |
| size_sel | input | 2 | Operand width code |
| out_valid | output | 1 | Result strobe, one cycle after the request |
| result | output | 64 | Rotated value, zero-extended |
| flags_out | output | 64 | Flags with carry and overflow replaced |

## Verification
There is no state carried between requests, so a fault in a lane or in the count reduction shows in the result or flags of the very request that exercises it, one cycle later. Such a fault would be a wrong modulus, a mask that is one bit off, or the carry entering the ring at the wrong position. The hard cases are counts equal to the width and to the width plus one, where the ring wraps exactly, and raw counts whose bits above the mask are set. A stuck or misplaced flag bit shows as a difference in `flags_out` against the untouched bits of `flags_in`.

// File: rtl/rcr_pkg.sv
package rcr_pkg;
  localparam int NUM_SIZES = 4;
  localparam int MIN_W     = 8;

  typedef enum logic [1:0] {
    SZ_8  = 2'b00,
    SZ_16 = 2'b01,
    SZ_32 = 2'b10,
    SZ_64 = 2'b11
  } size_e;

  function automatic int lane_width(input int idx);
    return MIN_W << idx;
  endfunction
endpackage

// File: rtl/rcr_count_reduce.sv
module rcr_count_reduce #(
  parameter int CNT_W = 8,
  parameter int EFF_W = 7
) (
  input  logic [CNT_W-1:0] raw,
  input  logic [1:0]       size,
  output logic [EFF_W-1:0] eff
);
  import rcr_pkg::*;

  logic [5:0] m6;
  logic [4:0] m5;
  logic [4:0] r8, r16, r32;

  always_comb begin
    m6  = raw[5:0];
    m5  = raw[4:0];
    r8  = m5 % 5'd9;
    r16 = m5 % 5'd17;
    // a 5-bit value never reaches 33, so the modulo-33 step leaves it alone
    r32 = m5;
    unique case (size_e'(size))
      SZ_8:    eff = EFF_W'(r8);
      SZ_16:   eff = EFF_W'(r16);
      SZ_32:   eff = EFF_W'(r32);
      default: eff = EFF_W'(m6);
    endcase
  end
endmodule

// File: rtl/rcr_ring_rotate.sv
module rcr_ring_rotate #(
  parameter int OP_W  = 64,
  parameter int EFF_W = 7
) (
  input  logic [OP_W-1:0]  operand,
  input  logic             carry_in,
  input  logic [1:0]       size,
  input  logic [EFF_W-1:0] eff,
  output logic [OP_W-1:0]  result,
  output logic             carry_out
);
  import rcr_pkg::*;

  logic [OP_W-1:0] lane_res [NUM_SIZES];
  logic            lane_cf  [NUM_SIZES];

  for (genvar g = 0; g < NUM_SIZES; g++) begin : g_lane
    localparam int LW = MIN_W << g;
    logic [LW:0]       ring;
    logic [2*LW+1:0]   dbl;
    always_comb begin
      ring        = {carry_in, operand[LW-1:0]};
      dbl         = {ring, ring} >> eff;
      lane_res[g] = OP_W'(dbl[LW-1:0]);
      lane_cf[g]  = dbl[LW];
    end
  end

  always_comb begin
    result    = lane_res[size];
    carry_out = lane_cf[size];
  end
endmodule

// File: rtl/rcr_flag_merge.sv
module rcr_flag_merge #(
  parameter int OP_W   = 64,
  parameter int FLAG_W = 64,
  parameter int CF_POS = 0,
  parameter int OF_POS = 11
) (
  input  logic [OP_W-1:0]   operand,
  input  logic [1:0]        size,
  input  logic [FLAG_W-1:0] flags_in,
  input  logic              new_cf,
  output logic [FLAG_W-1:0] flags_out
);
  import rcr_pkg::*;

  logic top_bit;
  logic ovf;

  always_comb begin
    unique case (size_e'(size))
      SZ_8:    top_bit = operand[7];
      SZ_16:   top_bit = operand[15];
      SZ_32:   top_bit = operand[31];
      default: top_bit = operand[OP_W-1];
    endcase
    ovf               = top_bit ^ flags_in[CF_POS];
    flags_out         = flags_in;
    flags_out[CF_POS] = new_cf;
    flags_out[OF_POS] = ovf;
  end
endmodule

// File: rtl/rcr_unit.sv
module rcr_unit #(
  parameter int OP_W   = 64,
  parameter int CNT_W  = 8,
  parameter int FLAG_W = 64,
  parameter int CF_POS = 0,
  parameter int OF_POS = 11
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [OP_W-1:0]   operand,
  input  logic [CNT_W-1:0]  count,
  input  logic [FLAG_W-1:0] flags_in,
  input  logic [1:0]        size_sel,
  output logic              out_valid,
  output logic [OP_W-1:0]   result,
  output logic [FLAG_W-1:0] flags_out
);
  localparam int EFF_W = $clog2(OP_W + 1);

  logic [EFF_W-1:0]  eff;
  logic [OP_W-1:0]   rot_res;
  logic              rot_cf;
  logic [FLAG_W-1:0] new_flags;

  rcr_count_reduce #(.CNT_W(CNT_W), .EFF_W(EFF_W)) u_reduce (
    .raw  (count),
    .size (size_sel),
    .eff  (eff)
  );

  rcr_ring_rotate #(.OP_W(OP_W), .EFF_W(EFF_W)) u_rotate (
    .operand   (operand),
    .carry_in  (flags_in[CF_POS]),
    .size      (size_sel),
    .eff       (eff),
    .result    (rot_res),
    .carry_out (rot_cf)
  );

  rcr_flag_merge #(.OP_W(OP_W), .FLAG_W(FLAG_W), .CF_POS(CF_POS), .OF_POS(OF_POS)) u_flags (
    .operand   (operand),
    .size      (size_sel),
    .flags_in  (flags_in),
    .new_cf    (rot_cf),
    .flags_out (new_flags)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      result    <= '0;
      flags_out <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        result    <= rot_res;
        flags_out <= new_flags;
      end
    end
  end
endmodule

// File: rtl/rcr_unit_checker.sv
module rcr_unit_checker #(
  parameter int OP_W   = 64,
  parameter int CNT_W  = 8,
  parameter int FLAG_W = 64,
  parameter int CF_POS = 0,
  parameter int OF_POS = 11
) (
  input logic              clk,
  input logic              rst,
  input logic              in_valid,
  input logic [OP_W-1:0]   operand,
  input logic [CNT_W-1:0]  count,
  input logic [FLAG_W-1:0] flags_in,
  input logic [1:0]        size_sel,
  input logic              out_valid,
  input logic [OP_W-1:0]   result,
  input logic [FLAG_W-1:0] flags_out
);
  localparam logic [FLAG_W-1:0] KEEP = ~((FLAG_W'(1) << CF_POS) | (FLAG_W'(1) << OF_POS));

  // R10: one result strobe per request
  a_r10_valid_follows: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);
  a_r10_no_spurious: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);
  a_r10_hold: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> ($stable(result) && $stable(flags_out)));

  // R6: untouched flag bits pass through
  a_r6_flags_pass: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> ((flags_out & KEEP) == $past(flags_in & KEEP)));

  // R7: upper result bits are zero for narrow sizes
  a_r7_upper_zero_8: assert property (@(posedge clk) disable iff (rst)
    (in_valid && size_sel == 2'b00) |=> (result[OP_W-1:8] == '0));
  a_r7_upper_zero_16: assert property (@(posedge clk) disable iff (rst)
    (in_valid && size_sel == 2'b01) |=> (result[OP_W-1:16] == '0));
  a_r7_upper_zero_32: assert property (@(posedge clk) disable iff (rst)
    (in_valid && size_sel == 2'b10) |=> (result[OP_W-1:32] == '0));

  // R4: overflow from pre-rotate top bit and incoming carry (64-bit lane)
  a_r4_overflow_64: assert property (@(posedge clk) disable iff (rst)
    (in_valid && size_sel == 2'b11) |=>
      (flags_out[OF_POS] == ($past(operand[OP_W-1]) ^ $past(flags_in[CF_POS]))));

  // R8: zero effective count in the 64-bit lane is an identity
  a_r8_zero_count_64: assert property (@(posedge clk) disable iff (rst)
    (in_valid && size_sel == 2'b11 && count[5:0] == 6'd0) |=>
      (result == $past(operand) && flags_out[CF_POS] == $past(flags_in[CF_POS])));

  // R11: reset clears the strobe
  a_r11_reset_clear: assert property (@(posedge clk)
    rst |=> !out_valid);
endmodule

bind rcr_unit rcr_unit_checker #(
  .OP_W(OP_W), .CNT_W(CNT_W), .FLAG_W(FLAG_W), .CF_POS(CF_POS), .OF_POS(OF_POS)
) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .operand(operand), .count(count),
  .flags_in(flags_in), .size_sel(size_sel), .out_valid(out_valid),
  .result(result), .flags_out(flags_out)
);

// File: tb/rcr_unit_bench.sv
module rcr_unit_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [63:0] operand = '0;
  logic [7:0]  count = '0;
  logic [63:0] flags_in = '0;
  logic [1:0]  size_sel = '0;
  logic        out_valid;
  logic [63:0] result;
  logic [63:0] flags_out;

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  rcr_unit u_rcr_unit (
    .clk(clk), .rst(rst), .in_valid(in_valid), .operand(operand), .count(count),
    .flags_in(flags_in), .size_sel(size_sel), .out_valid(out_valid),
    .result(result), .flags_out(flags_out)
  );

  // Step-by-step model: {flags, result}
  function automatic logic [127:0] model(input logic [63:0] op, input logic [7:0] cnt,
                                         input logic [63:0] fl, input logic [1:0] sz);
    int w = 8 << sz;
    int c;
    logic [63:0] a;
    logic [63:0] mask;
    logic cf, of, t;
    logic [63:0] fo;
    c    = (sz == 2'b11) ? int'(cnt & 8'h3F) : int'(cnt & 8'h1F);
    if (sz != 2'b11) c = c % (w + 1);
    mask = (w == 64) ? 64'hFFFF_FFFF_FFFF_FFFF : ((64'd1 << w) - 64'd1);
    a    = op & mask;
    cf   = fl[0];
    of   = cf ^ a[w-1];
    for (int i = 0; i < c; i++) begin
      t  = a[0];
      a  = (a >> 1) | ({63'd0, cf} << (w - 1));
      cf = t;
    end
    fo     = fl;
    fo[0]  = cf;
    fo[11] = of;
    return {fo, a};
  endfunction

  task automatic check(input string tag, input logic [63:0] got_r, input logic [63:0] exp_r,
                       input logic [63:0] got_f, input logic [63:0] exp_f);
    n_checks++;
    if (got_r !== exp_r || got_f !== exp_f) begin
      n_fail++;
      $display("FAIL %s: result %h flags %h, expected result %h flags %h",
               tag, got_r, got_f, exp_r, exp_f);
    end
  endtask

  task automatic run(input string tag, input logic [63:0] op, input logic [7:0] cnt,
                     input logic [63:0] fl, input logic [1:0] sz);
    logic [127:0] e;
    e = model(op, cnt, fl, sz);
    @(negedge clk);
    operand = op; count = cnt; flags_in = fl; size_sel = sz; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    n_checks++;
    if (out_valid !== 1'b1) begin
      n_fail++;
      $display("FAIL R10 %s: out_valid %b expected 1", tag, out_valid);
    end
    check(tag, result, e[63:0], flags_out, e[127:64]);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    logic [63:0] held_r, held_f;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    // R11: reset clears outputs
    n_checks++;
    if (out_valid !== 1'b0) begin
      n_fail++;
      $display("FAIL R11 out_valid %b expected 0", out_valid);
    end
    check("R11 reset outputs", result, 64'd0, flags_out, 64'd0);
    @(negedge clk);
    rst = 1'b0;

    // Directed corners for every size (R9 encodings 00/01/10/11)
    for (int s = 0; s < 4; s++) begin
      int w = 8 << s;
      run("R8 zero count",   64'hA5C3_0F96_5A3C_F069, 8'd0, 64'h0000_0000_0000_0001, 2'(s));
      run("R5 ovf count0",   64'h8000_8000_8080_8080, 8'd0, 64'h0000_0000_0000_0000, 2'(s));
      run("R3 count one",    64'h1234_5678_9ABC_DEF1, 8'd1, 64'hFFFF_FFFF_FFFF_F7FE, 2'(s));
      run("R3 count width",  64'hDEAD_BEEF_CAFE_F00D, 8'(w), 64'h0000_0000_0000_0001, 2'(s));
      run("R2 count width+1",64'hDEAD_BEEF_CAFE_F00D, 8'(w + 1), 64'h0000_0000_0000_0801, 2'(s));
      run("R1 mask limit 31",64'h0F0F_F0F0_3C3C_C3C3, 8'd31, 64'h0000_0000_0000_0001, 2'(s));
      run("R1 mask bit 5",   64'h0F0F_F0F0_3C3C_C3C3, 8'd32, 64'h0000_0000_0000_0000, 2'(s));
      run("R1 mask limit 63",64'h0123_4567_89AB_CDEF, 8'd63, 64'h0000_0000_0000_0001, 2'(s));
      run("R1 high bits",    64'h0123_4567_89AB_CDEF, 8'hC3, 64'h5555_5555_5555_5555, 2'(s));
      run("R7 upper ignored",64'hFFFF_FFFF_FFFF_FFFF, 8'd3, 64'h0000_0000_0000_0000, 2'(s));
      run("R4 ovf set",      64'h0000_0000_0000_0000, 8'd5, 64'h0000_0000_0000_0001, 2'(s));
      run("R6 flags pass",   64'h0000_0000_0000_0055, 8'd2, 64'hA5A5_A5A5_A5A5_A5A5, 2'(s));
    end

    // R10: outputs hold and strobe stays low with no request
    held_r = result; held_f = flags_out;
    operand = 64'hFFFF_0000_FFFF_0000; count = 8'd7; flags_in = '1;
    repeat (2) @(negedge clk);
    n_checks++;
    if (out_valid !== 1'b0) begin
      n_fail++;
      $display("FAIL R10 idle out_valid %b expected 0", out_valid);
    end
    check("R10 hold", result, held_r, flags_out, held_f);

    // Random mix for R2/R3/R4
    for (int i = 0; i < 400; i++) begin
      run("R3 random", {$urandom, $urandom}, 8'($urandom), {$urandom, $urandom}, 2'($urandom));
    end

    finished = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule